// File: doc/BRIEF.md
# Segmented Address Translation Checker

This block turns one logical memory access into a linear address within one registered cycle. A requester presents a 32-bit offset and the cached fields of the segment descriptor that the access goes through: base, 20-bit limit, granularity, default-size bit, code/data type, the direction-or-conforming bit, the read-or-write permission bit and the present bit. It also presents the kind of access (read, write or instruction fetch). The block adds the base to the offset. It checks the offset against the segment's bounds and checks the access kind against the segment's type. On the next clock edge it returns either a valid linear address or a fault code.

Paging is not part of this stage, so the linear address can be used directly as the physical address. Privilege levels, gates and privilege transitions are handled elsewhere. The block looks only at the descriptor fields it is given. It is meant to sit between address generation and the memory request in a pipeline. The one-cycle latency is fixed, and an idle cycle gives an empty result.

Top module: `seg_xlate`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs become `lin_valid`=0, `fault`=0 and `lin_addr`=0.
- R2: Results appear exactly one clock after `acc_en` is sampled high. A cycle with `acc_en` low gives `lin_valid`=0, `fault`=0 and `lin_addr`=0 on the next edge.
- R3: For an accepted access, `lin_addr` equals `seg_base` + `offset` taken modulo 2^32. A carry out of bit 31 is dropped silently and never causes a fault.
- R4: With `seg_gran`=0 the effective limit is the 20-bit limit in bytes. With `seg_gran`=1 it is the limit times 4096 plus 4095, so the low 12 bits are all ones.
- R5: For a code segment, or for a data segment with `seg_dir`=0 (grows upward), an offset is in range when it is less than or equal to the effective limit. Any other offset gives the limit fault.
- R6: For a data segment with `seg_dir`=1 (grows downward), an offset is in range when it is above the effective limit and no higher than the top offset. The top offset is 0xFFFFFFFF when `seg_big`=1 and 0x0000FFFF when `seg_big`=0. On a code segment `seg_dir` has no effect on the range.
- R7: A write (`acc_kind`=2'b01) faults with write-protect when the segment is code, or when it is data with `seg_rw`=0.
- R8: A read (`acc_kind`=2'b00, and 2'b11 is treated the same) faults with read-protect only when the segment is code with `seg_rw`=0. A data segment can always be read.
- R9: An instruction fetch (`acc_kind`=2'b10) faults with execute-protect when the segment is data. A code segment can always be fetched, whatever its `seg_rw` value.
- R10: Fault codes are 0 none, 1 limit, 2 write-protect, 3 read-protect, 4 execute-protect, 5 not-present. `seg_present`=0 reports code 5 for every access kind and offset. Otherwise a limit fault wins over any permission fault.
- R11: `lin_valid` is 1 exactly when the accepted access has fault code 0. Whenever `lin_valid` is 0, `lin_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_en | input | 1 | An access is presented this cycle |
| acc_kind | input | 2 | 00 read, 01 write, 10 fetch, 11 read |
| offset | input | 32 | Offset within the segment |
| seg_base | input | 32 | Segment base address |
| seg_limit | input | 20 | Raw segment limit |
| seg_gran | input | 1 | 1: limit counts 4096-byte pages |
| seg_big | input | 1 | 1: top offset 0xFFFFFFFF, 0: top offset 0xFFFF |
| seg_code | input | 1 | 1: code segment, 0: data segment |
| seg_dir | input | 1 | Data: 1 means grows downward; ignored for code |
| seg_rw | input | 1 | Data: writable; code: readable |
| seg_present | input | 1 | Segment is present |
| lin_addr | output | 32 | Linear address, 0 when not valid |
| lin_valid | output | 1 | Access accepted with no fault |
| fault | output | 3 | Fault code |

## Verification
Several rules are checked by properties on every clock edge. Valid and a nonzero fault never appear together, and a rejected result always carries address 0. An idle cycle always gives an empty result. A valid address is always the wrapped sum of the base and offset from the previous cycle. An absent segment always reports code 5, and a write to code or a fetch from data is never accepted. The bench's sweeps are needed for the boundary behaviour that depends on the value of the limit. This covers the last in-range offset and the first out-of-range offset under both granularities, the downward-growing window with both top offsets, the order in which faults take priority, and carry wrap in the adder.

// File: rtl/seg_xlate_pkg.sv
// Package: shared encodings for the segment translation stage.
// Assumes a 2-bit access kind and a 3-bit fault code on the top ports.
package seg_xlate_pkg;

    typedef enum logic [1:0] {
        ACC_READ     = 2'b00,
        ACC_WRITE    = 2'b01,
        ACC_FETCH    = 2'b10,
        ACC_READ_ALT = 2'b11
    } acc_kind_e;

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_LIMIT  = 3'd1,
        FLT_WPROT  = 3'd2,
        FLT_RPROT  = 3'd3,
        FLT_XPROT  = 3'd4,
        FLT_ABSENT = 3'd5
    } fault_e;

endpackage

// File: rtl/seg_limit_chk.sv
// Module: seg_limit_chk
// Decides whether an offset lies inside a segment's valid window.
// Handles byte and page granularity and both growth directions.
// Assumes ADDR_W = LIMIT_W + page shift, and SMALL_W <= ADDR_W.
module seg_limit_chk #(
    parameter int ADDR_W  = 32,
    parameter int LIMIT_W = 20,
    parameter int SMALL_W = 16
) (
    input  logic [ADDR_W-1:0]  offset,
    input  logic [LIMIT_W-1:0] limit,
    input  logic               gran,
    input  logic               big,
    input  logic               grows_down,
    output logic               in_range
);
    localparam int PAGE_SHIFT = ADDR_W - LIMIT_W;

    logic [ADDR_W-1:0] eff_limit;
    logic [ADDR_W-1:0] top_offset;

    // Scale the raw limit to bytes, filling the page remainder with ones.
    always_comb begin
        eff_limit = gran ? {limit, {PAGE_SHIFT{1'b1}}}
                         : {{PAGE_SHIFT{1'b0}}, limit};
    end

    // Pick the highest reachable offset, chosen by the default-size bit.
    generate
        if (SMALL_W >= ADDR_W) begin : g_full_small
            always_comb top_offset = {ADDR_W{1'b1}};
        end else begin : g_narrow_small
            always_comb top_offset = big ? {ADDR_W{1'b1}}
                                         : {{(ADDR_W-SMALL_W){1'b0}}, {SMALL_W{1'b1}}};
        end
    endgenerate

    // Compare the offset against the window for the segment's direction.
    always_comb begin
        if (grows_down)
            in_range = (offset > eff_limit) && (offset <= top_offset);
        else
            in_range = (offset <= eff_limit);
    end
endmodule

// File: rtl/seg_perm_chk.sv
// Module: seg_perm_chk
// Checks an access kind against the segment type and its read/write bit.
// Assumes the caller gives limit and presence faults priority over this one.
module seg_perm_chk
    import seg_xlate_pkg::*;
(
    input  logic [1:0] kind,
    input  logic       is_code,
    input  logic       rw_bit,
    output fault_e     perm_fault
);
    // Apply the type rules for each access kind.
    always_comb begin
        unique case (acc_kind_e'(kind))
            ACC_WRITE: perm_fault = (is_code || !rw_bit) ? FLT_WPROT : FLT_NONE;
            ACC_FETCH: perm_fault = is_code ? FLT_NONE : FLT_XPROT;
            default:   perm_fault = (is_code && !rw_bit) ? FLT_RPROT : FLT_NONE;
        endcase
    end
endmodule

// File: rtl/seg_addr_add.sv
// Module: seg_addr_add
// Forms the linear address as base plus offset, wrapping modulo 2^ADDR_W.
// Assumes the carry out is discarded on purpose.
module seg_addr_add #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] offset,
    output logic [ADDR_W-1:0] sum
);
    // Add with a truncating width so the carry out is dropped.
    always_comb sum = base + offset;
endmodule

// File: rtl/seg_xlate.sv
// Module: seg_xlate
// A one-cycle registered stage that turns a segment offset into a linear
// address, or reports why the access is refused.
// Assumes the descriptor fields are stable while acc_en is high, and that
// privilege checks happen elsewhere.
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int LIMIT_W = 20,
    parameter int SMALL_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_en,
    input  logic [1:0]         acc_kind,
    input  logic [ADDR_W-1:0]  offset,
    input  logic [ADDR_W-1:0]  seg_base,
    input  logic [LIMIT_W-1:0] seg_limit,
    input  logic               seg_gran,
    input  logic               seg_big,
    input  logic               seg_code,
    input  logic               seg_dir,
    input  logic               seg_rw,
    input  logic               seg_present,
    output logic [ADDR_W-1:0]  lin_addr,
    output logic               lin_valid,
    output logic [2:0]         fault
);
    logic              grows_down;
    logic              in_range;
    fault_e            perm_fault;
    fault_e            next_fault;
    logic [ADDR_W-1:0] sum;

    // The direction bit only applies to data segments.
    always_comb grows_down = seg_dir && !seg_code;

    seg_limit_chk #(
        .ADDR_W  (ADDR_W),
        .LIMIT_W (LIMIT_W),
        .SMALL_W (SMALL_W)
    ) u_limit (
        .offset     (offset),
        .limit      (seg_limit),
        .gran       (seg_gran),
        .big        (seg_big),
        .grows_down (grows_down),
        .in_range   (in_range)
    );

    seg_perm_chk u_perm (
        .kind       (acc_kind),
        .is_code    (seg_code),
        .rw_bit     (seg_rw),
        .perm_fault (perm_fault)
    );

    seg_addr_add #(
        .ADDR_W (ADDR_W)
    ) u_add (
        .base   (seg_base),
        .offset (offset),
        .sum    (sum)
    );

    // Rank the faults: absent first, then limit, then permission.
    always_comb begin
        if (!seg_present)
            next_fault = FLT_ABSENT;
        else if (!in_range)
            next_fault = FLT_LIMIT;
        else
            next_fault = perm_fault;
    end

    // Register the result. Idle cycles and refused accesses give a zero address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lin_addr  <= '0;
            lin_valid <= 1'b0;
            fault     <= FLT_NONE;
        end else if (acc_en) begin
            lin_valid <= (next_fault == FLT_NONE);
            fault     <= next_fault;
            lin_addr  <= (next_fault == FLT_NONE) ? sum : '0;
        end else begin
            lin_addr  <= '0;
            lin_valid <= 1'b0;
            fault     <= FLT_NONE;
        end
    end
endmodule

// File: rtl/seg_xlate_chk.sv
// Module: seg_xlate_chk
// Property checker for seg_xlate, attached to the top module by bind.
// Assumes its port names match the top module's port names.
module seg_xlate_chk #(
    parameter int ADDR_W  = 32,
    parameter int LIMIT_W = 20
) (
    input logic               clk,
    input logic               rst_n,
    input logic               acc_en,
    input logic [1:0]         acc_kind,
    input logic [ADDR_W-1:0]  offset,
    input logic [ADDR_W-1:0]  seg_base,
    input logic [LIMIT_W-1:0] seg_limit,
    input logic               seg_gran,
    input logic               seg_big,
    input logic               seg_code,
    input logic               seg_dir,
    input logic               seg_rw,
    input logic               seg_present,
    input logic [ADDR_W-1:0]  lin_addr,
    input logic               lin_valid,
    input logic [2:0]         fault
);
    // R11: a valid result never carries a fault code.
    a_r11_valid_clean: assert property (@(posedge clk) disable iff (!rst_n)
        lin_valid |-> (fault == 3'd0));

    // R11: a refused or empty result always carries address zero.
    a_r11_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
        !lin_valid |-> (lin_addr == '0));

    // R2: an idle cycle after reset gives an empty result.
    a_r2_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(acc_en)) |-> (!lin_valid && fault == 3'd0));

    // R3: a valid address is the wrapped sum of the previous cycle's inputs.
    a_r3_wrapped_sum: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && lin_valid) |->
            (lin_addr == ADDR_W'($past(seg_base) + $past(offset))));

    // R10: an absent segment always reports the not-present code.
    a_r10_absent: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(acc_en) && !$past(seg_present)) |-> (fault == 3'd5));

    // R7: a write to a code segment is never accepted.
    a_r7_code_write: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(acc_en) && $past(seg_code) && $past(acc_kind) == 2'b01)
            |-> !lin_valid);

    // R9: a fetch from a data segment is never accepted.
    a_r9_data_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(acc_en) && !$past(seg_code) && $past(acc_kind) == 2'b10)
            |-> !lin_valid);
endmodule

bind seg_xlate seg_xlate_chk #(.ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W)) u_chk (.*);

// File: tb/seg_xlate_bench.sv
`timescale 1ns/1ps
// Bench: sweeps every descriptor-flag combination against boundary offsets
// and computes the expected results arithmetically.
module seg_xlate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0;
    logic [1:0]  acc_kind = 2'b00;
    logic [31:0] offset = '0;
    logic [31:0] seg_base = '0;
    logic [19:0] seg_limit = '0;
    logic        seg_gran = 1'b0, seg_big = 1'b0, seg_code = 1'b0;
    logic        seg_dir = 1'b0, seg_rw = 1'b0, seg_present = 1'b0;
    logic [31:0] lin_addr;
    logic        lin_valid;
    logic [2:0]  fault;

    int vectors = 0;
    int misses  = 0;

    always #4 clk = ~clk;

    seg_xlate u_seg_xlate (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_kind(acc_kind),
        .offset(offset), .seg_base(seg_base), .seg_limit(seg_limit),
        .seg_gran(seg_gran), .seg_big(seg_big), .seg_code(seg_code),
        .seg_dir(seg_dir), .seg_rw(seg_rw), .seg_present(seg_present),
        .lin_addr(lin_addr), .lin_valid(lin_valid), .fault(fault)
    );

    // Reference fault code, built from the requirement text.
    function automatic int ref_fault(input int kind, input bit code, input bit dir,
                                     input bit rw, input bit gran, input bit big,
                                     input bit present, input longint lim,
                                     input longint off);
        longint eff;
        longint top;
        bit ok;
        if (!present) return 5;
        eff = gran ? (lim * 4096 + 4095) : lim;
        top = big ? 64'hFFFF_FFFF : 64'hFFFF;
        if (dir && !code) ok = (off > eff) && (off <= top);
        else              ok = (off <= eff);
        if (!ok) return 1;
        if (kind == 1) return (code || !rw) ? 2 : 0;
        if (kind == 2) return code ? 0 : 4;
        return (code && !rw) ? 3 : 0;
    endfunction

    // Compare the outputs with the expected values and report any mismatch.
    task automatic check(input string req, input bit ev, input int ef, input logic [31:0] ea);
        vectors++;
        if (lin_valid !== ev || fault !== 3'(ef) || lin_addr !== ea) begin
            misses++;
            $display("FAIL %s: actual valid=%0b fault=%0d addr=%h expected valid=%0b fault=%0d addr=%h",
                     req, lin_valid, fault, lin_addr, ev, ef, ea);
        end
    endtask

    // Pick a boundary offset for the given effective limit.
    function automatic longint pick_off(input int i, input longint eff);
        case (i)
            0: return 0;
            1: return eff;
            2: return (eff + 1) & 64'hFFFF_FFFF;
            3: return 64'hFFFF;
            4: return 64'h1_0000;
            5: return 64'hFFFF_FFFF;
            6: return (eff == 0) ? 0 : eff - 1;
            default: return 64'h0008_0000;
        endcase
    endfunction

    initial begin : run
        longint lims [3] = '{64'h00123, 64'h0000F, 64'hFFFFF};
        // R1: reset state
        repeat (2) @(posedge clk);
        #1 check("R1", 1'b0, 0, 32'h0);
        @(negedge clk) rst_n = 1'b1;
        // R2: an idle cycle after reset
        @(posedge clk); #1 check("R2", 1'b0, 0, 32'h0);
        for (int l = 0; l < 3; l++) begin
            for (int cfg = 0; cfg < 256; cfg++) begin
                for (int i = 0; i < 8; i++) begin
                    int kind;
                    bit code, dir, rw, gran, big, pres;
                    longint eff, off, base;
                    int ef;
                    string req;
                    kind = cfg & 3;
                    code = cfg[2]; dir = cfg[3]; rw = cfg[4];
                    gran = cfg[5]; big = cfg[6]; pres = cfg[7];
                    eff  = gran ? (lims[l] * 4096 + 4095) : lims[l];
                    off  = pick_off(i, eff);
                    base = (i[0]) ? 64'hFFFF_F800 : (longint'(cfg) * 64'h0101_0101) & 64'hFFFF_FFFF;
                    ef = ref_fault(kind, code, dir, rw, gran, big, pres, lims[l], off);
                    case (ef)
                        5: req = "R10";
                        1: req = gran ? "R4" : ((dir && !code) ? "R6" : "R5");
                        2: req = "R7";
                        3: req = "R8";
                        4: req = "R9";
                        default: req = "R3";
                    endcase
                    @(negedge clk);
                    acc_en = 1'b1; acc_kind = 2'(kind); offset = 32'(off);
                    seg_base = 32'(base); seg_limit = 20'(lims[l]);
                    seg_gran = gran; seg_big = big; seg_code = code;
                    seg_dir = dir; seg_rw = rw; seg_present = pres;
                    @(posedge clk); #1;
                    check((ef == 0) ? req : {req, "/R11"}, (ef == 0), ef,
                          (ef == 0) ? 32'((base + off) & 64'hFFFF_FFFF) : 32'h0);
                end
                // R2: an idle cycle between configurations
                @(negedge clk) acc_en = 1'b0;
                @(posedge clk); #1 check("R2", 1'b0, 0, 32'h0);
            end
        end
        // R1: reset during an active access
        @(negedge clk) begin acc_en = 1'b1; seg_present = 1'b0; rst_n = 1'b0; end
        @(posedge clk); #1 check("R1", 1'b0, 0, 32'h0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    // Watchdog: end a hung run as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        misses++;
        $display("FAIL R2: watchdog expired, actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule